// File: doc/BRIEF.md
# Block Lock Protection Controller

This block guards the array of a sixteen-block flash memory against unwanted changes. It keeps one lock bit per block plus a master bit, and for each request to erase a block, program a byte, set a block's lock bit, set the master bit or wipe all block bits, it returns either a one-cycle grant or a one-cycle lock error. The block bits guard array changes. The master bit guards changes to the block bits. A high-voltage level on the reset pin, seen here as a plain input flag, overrides both.

The lock bits stand in for non-volatile cells and are held in flops. A side port serves the identifier space, so software can find out which blocks are protected. The same port also returns two fixed code bytes. The block index is the top four address bits, and the offset is the low sixteen bits.

Top module: `blk_lock_guard`

## Requirements
- R1: After a synchronous reset, all sixteen block bits and the master bit are clear, and `grant` and `lock_err` are low.
- R2: Erase (op 1) or program (op 2) is granted when the addressed block's bit is clear. When the bit is set, it is granted only with `hv_override` high and is otherwise denied. The block index is `req_addr[19:16]`.
- R3: Set-block (op 3) is granted when the master bit is clear or `hv_override` is high. A grant sets only the addressed block's bit.
- R4: Clear-all (op 5) follows the same rule as R3. A grant clears all sixteen block bits and leaves the master bit as it was.
- R5: Set-master (op 4) is granted only with `hv_override` high, whatever the other bits hold.
- R6: A denied request raises `lock_err` and changes neither the block bits nor the master bit.
- R7: `grant` and `lock_err` are registered. They are high for exactly the one cycle after the request edge, and never both at once.
- R8: Identifier offset 2 (low sixteen address bits equal to 0002H) in any block returns that block's bit on data bit 0. Offset 3 in block 0 returns the master bit on data bit 0. Data bits 1 to 7 read zero.
- R9: Identifier address 00000H reads 89H and 00001H reads A6H. Every other identifier location reads 00H.
- R10: With `req_valid` low, or with op 0, 6 or 7, there is no grant, no error and no change to any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled on the clock edge |
| req_op | input | 3 | Operation code: 0 none, 1 erase, 2 program, 3 set block, 4 set master, 5 clear all |
| req_addr | input | 20 | Request address; bits 19:16 pick the block |
| hv_override | input | 1 | Reset pin sits at the high-voltage level |
| grant | output | 1 | One-cycle permit pulse |
| lock_err | output | 1 | One-cycle denial pulse toward the status register |
| id_addr | input | 20 | Identifier-space read address |
| id_data | output | 8 | Identifier-space read data (combinational) |

## Verification
The assertions assume that `hv_override` and the request fields hold steady across the edge that samples them. They also assume that reset is held for at least two cycles, so every `$past` term sees reset values. The bench meets both assumptions: it changes every input on the falling edge and holds reset for four cycles. Identifier reads are driven and sampled between clock edges, while no request is in flight.

// File: rtl/lkg_pkg.sv
package lkg_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ERASE    = 3'd1,
        OP_PROGRAM  = 3'd2,
        OP_SET_BLK  = 3'd3,
        OP_SET_MST  = 3'd4,
        OP_CLR_ALL  = 3'd5
    } lkg_op_e;

    typedef struct packed {
        logic grant;
        logic deny;
        logic wr_blk;
        logic wr_mst;
        logic clr_all;
    } lkg_verdict_t;

    localparam lkg_verdict_t VERDICT_IDLE = '{default: 1'b0};

    function automatic logic op_touches_array(input lkg_op_e op);
        return (op == OP_ERASE) || (op == OP_PROGRAM);
    endfunction

    function automatic logic op_touches_blkbits(input lkg_op_e op);
        return (op == OP_SET_BLK) || (op == OP_CLR_ALL);
    endfunction

endpackage

// File: rtl/lkg_decide.sv
module lkg_decide
    import lkg_pkg::*;
#(
    parameter int NUM_BLK = 16,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               valid,
    input  logic [2:0]         op_raw,
    input  logic [BLK_W-1:0]   blk_idx,
    input  logic               hv,
    input  logic [NUM_BLK-1:0] blk_locks,
    input  logic               master,
    output lkg_verdict_t       verdict
);

    lkg_op_e op;
    logic    known;
    logic    allowed;

    always_comb begin
        op    = lkg_op_e'(op_raw);
        known = 1'b1;
        case (op_raw)
            3'd1, 3'd2:
                allowed = !blk_locks[blk_idx] || hv;
            3'd3, 3'd5:
                allowed = !master || hv;
            3'd4:
                allowed = hv;
            default: begin
                allowed = 1'b0;
                known   = 1'b0;
            end
        endcase
    end

    always_comb begin
        verdict = VERDICT_IDLE;
        if (valid && known) begin
            verdict.grant = allowed;
            verdict.deny  = !allowed;
            if (allowed) begin
                verdict.wr_blk  = (op == OP_SET_BLK);
                verdict.wr_mst  = (op == OP_SET_MST);
                verdict.clr_all = (op == OP_CLR_ALL);
            end
        end
    end

    always_comb begin
        assert (!(verdict.grant && verdict.deny)); // R7
        assert (!(verdict.wr_blk && !verdict.grant)); // R6
    end

endmodule

// File: rtl/lkg_store.sv
module lkg_store
    import lkg_pkg::*;
#(
    parameter int NUM_BLK = 16,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  lkg_verdict_t       verdict,
    input  logic [BLK_W-1:0]   blk_idx,
    input  logic               hv,
    output logic [NUM_BLK-1:0] blk_locks,
    output logic               master
);

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                blk_locks[g] <= 1'b0;
            else if (verdict.clr_all)
                blk_locks[g] <= 1'b0;
            else if (verdict.wr_blk && blk_idx == BLK_W'(g))
                blk_locks[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            master <= 1'b0;
        else if (verdict.wr_mst)
            master <= 1'b1;
    end

    AST_MASTER_NEEDS_HV: assert property (@(posedge clk) disable iff (rst)
        (master && !$past(master)) |-> $past(hv)); // R5

    AST_ONE_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        $countones(blk_locks & ~$past(blk_locks)) <= 1); // R3

    AST_CLEAR_IS_TOTAL: assert property (@(posedge clk) disable iff (rst)
        (|($past(blk_locks) & ~blk_locks)) |-> (blk_locks == '0)); // R4

    AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(master) |-> master); // R4

endmodule

// File: rtl/lkg_idmap.sv
module lkg_idmap #(
    parameter int         NUM_BLK  = 16,
    parameter int         ADDR_W   = 20,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] MFR_CODE = 8'h89,
    parameter logic [7:0] DEV_CODE = 8'hA6,
    localparam int BLK_W = $clog2(NUM_BLK),
    localparam int OFS_W = ADDR_W - BLK_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_BLK-1:0] blk_locks,
    input  logic               master,
    output logic [DATA_W-1:0]  data
);

    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;

    assign blk = addr[ADDR_W-1 -: BLK_W];
    assign ofs = addr[OFS_W-1:0];

    always_comb begin
        data = '0;
        if (ofs == OFS_W'(2))
            data[0] = blk_locks[blk];
        else if (blk == '0) begin
            if (ofs == OFS_W'(0))
                data = DATA_W'(MFR_CODE);
            else if (ofs == OFS_W'(1))
                data = DATA_W'(DEV_CODE);
            else if (ofs == OFS_W'(3))
                data[0] = master;
        end
    end

    always_comb begin
        if (ofs > OFS_W'(1))
            assert (data[DATA_W-1:1] == '0); // R8
    end

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
    import lkg_pkg::*;
#(
    parameter int         NUM_BLK  = 16,
    parameter int         ADDR_W   = 20,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] MFR_CODE = 8'h89,
    parameter logic [7:0] DEV_CODE = 8'hA6,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hv_override,
    output logic              grant,
    output logic              lock_err,
    input  logic [ADDR_W-1:0] id_addr,
    output logic [DATA_W-1:0] id_data
);

    logic [BLK_W-1:0]   blk_idx;
    logic [NUM_BLK-1:0] blk_locks;
    logic               master;
    lkg_verdict_t       verdict;

    assign blk_idx = req_addr[ADDR_W-1 -: BLK_W];

    lkg_decide #(.NUM_BLK(NUM_BLK)) i_decide (
        .valid     (req_valid),
        .op_raw    (req_op),
        .blk_idx   (blk_idx),
        .hv        (hv_override),
        .blk_locks (blk_locks),
        .master    (master),
        .verdict   (verdict)
    );

    lkg_store #(.NUM_BLK(NUM_BLK)) i_store (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .blk_idx   (blk_idx),
        .hv        (hv_override),
        .blk_locks (blk_locks),
        .master    (master)
    );

    lkg_idmap #(
        .NUM_BLK  (NUM_BLK),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) i_idmap (
        .addr      (id_addr),
        .blk_locks (blk_locks),
        .master    (master),
        .data      (id_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant    <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            grant    <= verdict.grant;
            lock_err <= verdict.deny;
        end
    end

    AST_GRANT_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(grant && lock_err)); // R7

    AST_DENY_FREEZES: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> ($stable(blk_locks) && $stable(master))); // R6

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant && !lock_err)); // R10

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(blk_locks) && $stable(master))); // R10

    AST_LOCKED_ARRAY_DENY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_touches_array(lkg_op_e'(req_op))
            && blk_locks[blk_idx] && !hv_override) |=> lock_err); // R2

endmodule

// File: tb/test_blk_lock_guard.sv
`timescale 1ns/1ps
module test_blk_lock_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [19:0] req_addr;
    logic        hv_override;
    logic        grant;
    logic        lock_err;
    logic [19:0] id_addr;
    logic [7:0]  id_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] mdl_blk;
    logic        mdl_mst;

    always #2.5 clk = ~clk;

    blk_lock_guard i_blk_lock_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .hv_override(hv_override), .grant(grant),
        .lock_err(lock_err), .id_addr(id_addr), .id_data(id_data)
    );

    // vector fields: op[9:7] blk[6:3] hv[2] exp_grant[1] exp_err[0]
    localparam int NV = 17;
    localparam logic [9:0] VEC [NV] = '{
        {3'd1, 4'd3,  1'b0, 1'b1, 1'b0},   // R2 erase unlocked
        {3'd3, 4'd3,  1'b0, 1'b1, 1'b0},   // R3 set blk, master clear
        {3'd1, 4'd3,  1'b0, 1'b0, 1'b1},   // R2 erase locked
        {3'd2, 4'd3,  1'b0, 1'b0, 1'b1},   // R2 program locked
        {3'd2, 4'd3,  1'b1, 1'b1, 1'b0},   // R2 override
        {3'd2, 4'd4,  1'b0, 1'b1, 1'b0},   // R2 neighbour unlocked
        {3'd3, 4'd15, 1'b0, 1'b1, 1'b0},   // R3 top block
        {3'd4, 4'd0,  1'b0, 1'b0, 1'b1},   // R5 no hv
        {3'd4, 4'd0,  1'b1, 1'b1, 1'b0},   // R5 hv
        {3'd3, 4'd0,  1'b0, 1'b0, 1'b1},   // R3 master set
        {3'd5, 4'd0,  1'b0, 1'b0, 1'b1},   // R4 master set
        {3'd3, 4'd0,  1'b1, 1'b1, 1'b0},   // R3 override
        {3'd1, 4'd15, 1'b0, 1'b0, 1'b1},   // R2 locked top
        {3'd5, 4'd7,  1'b1, 1'b1, 1'b0},   // R4 override clears all
        {3'd1, 4'd15, 1'b0, 1'b1, 1'b0},   // R2 after clear
        {3'd0, 4'd2,  1'b0, 1'b0, 1'b0},   // R10 op none
        {3'd7, 4'd2,  1'b1, 1'b0, 1'b0}    // R10 reserved op
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic id_read(input logic [19:0] a, input logic [7:0] exp, input string req);
        id_addr = a;
        #0.5;
        chk(req, id_data, exp);
    endtask

    task automatic send(input logic [2:0] op, input logic [3:0] blk,
                        input logic hv, input logic vld);
        @(negedge clk);
        req_valid   = vld;
        req_op      = op;
        req_addr    = {blk, 16'h5a5a};
        hv_override = hv;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0;
        hv_override = 1'b0; id_addr = '0;
        mdl_blk = '0; mdl_mst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 grant", {7'd0, grant}, 8'h00);
        chk("R1 lock_err", {7'd0, lock_err}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < 16; b++)
            id_read({b[3:0], 16'h0002}, 8'h00, "R1 block bit");
        id_read(20'h00003, 8'h00, "R1 master bit");
        id_read(20'h00000, 8'h89, "R9 manufacturer");
        id_read(20'h00001, 8'hA6, "R9 device");
        id_read(20'h50003, 8'h00, "R9 offset 3 off block 0");
        id_read(20'h10000, 8'h00, "R9 offset 0 off block 0");
        id_read(20'h00004, 8'h00, "R9 reserved");

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [3:0] blk;
            op  = VEC[i][9:7];
            blk = VEC[i][6:3];
            send(op, blk, VEC[i][2], 1'b1);
            chk($sformatf("R7 grant vec %0d", i), {7'd0, grant}, {7'd0, VEC[i][1]});
            chk($sformatf("R6 lock_err vec %0d", i), {7'd0, lock_err}, {7'd0, VEC[i][0]});
            if (VEC[i][1]) begin
                if (op == 3'd3) mdl_blk[blk] = 1'b1;
                if (op == 3'd4) mdl_mst = 1'b1;
                if (op == 3'd5) mdl_blk = '0;
            end
            id_read({blk, 16'h0002}, {7'd0, mdl_blk[blk]}, "R8 block bit");
            id_read(20'h00003, {7'd0, mdl_mst}, "R8 master bit");
            @(posedge clk);
            #1;
            chk("R7 single pulse", {6'd0, grant, lock_err}, 8'h00);
        end

        for (int b = 0; b < 16; b++)
            id_read({b[3:0], 16'h0002}, {7'd0, mdl_blk[b]}, "R4 bits after clear");

        // locked block with strobe low: nothing happens
        send(3'd3, 4'd9, 1'b1, 1'b1);
        chk("R3 set blk 9", {7'd0, grant}, 8'h01);
        send(3'd5, 4'd0, 1'b1, 1'b0);
        chk("R10 strobe low", {6'd0, grant, lock_err}, 8'h00);
        id_read({4'd9, 16'h0002}, 8'h01, "R10 bit kept");
        send(3'd6, 4'd9, 1'b1, 1'b1);
        chk("R10 op 6", {6'd0, grant, lock_err}, 8'h00);
        id_read({4'd9, 16'h0002}, 8'h01, "R10 bit kept op 6");
        id_read({4'd8, 16'h0002}, 8'h00, "R3 neighbour clear");

        // reset drops all state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        id_read({4'd9, 16'h0002}, 8'h00, "R1 bit after reset");
        id_read(20'h00003, 8'h00, "R1 master after reset");
        @(negedge clk);
        rst = 1'b0;
        send(3'd4, 4'd0, 1'b0, 1'b1);
        chk("R5 after reset no hv", {6'd0, grant, lock_err}, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule